// File: doc/BRIEF.md
# Link-Layer Retry Transmitter

This block is the sending half of a reliable point-to-point link layer. Packets arrive on a word-wide upstream stream (valid, ready, last). Each packet is written into a replay store, given the next 12-bit sequence number and closed with a 32-bit CRC word. The stored frame is then sent downstream. The sequence number travels on a sideband that stays constant for the whole frame.

Frames stay in the store until the far end accepts them. A positive acknowledge is cumulative and releases every frame up to the number it carries. A negative acknowledge resends every held frame from the named number onward, in order and bit-for-bit identical. A programmable replay timer triggers the same full resend when acknowledges stop arriving. Acknowledges that name a number outside the window of sent, unreleased frames are dropped, and a sticky error flag records them.

Because every frame is sent from the store, first transmissions and retransmissions share one read path. A resend request takes effect only at a frame boundary, so a downstream frame is never cut short.

Top module: `rtx_retry_tx`

## Requirements
- R1: After reset the first packet carries sequence number 0. Each later packet carries the previous number plus one, modulo 4096 (4095 is followed by 0). `out_seq` holds the frame's number on every word of that frame.
- R2: Each frame is its payload words in arrival order, followed by one CRC word. `out_last` is high only on the CRC word. The CRC is computed MSB-first over a 32-bit word that holds the sequence number in bits 11:0 (upper bits zero), then over each payload word. It uses polynomial 0x04C11DB7, starts from all ones, and the result is complemented. A packet has 1 to MAXW payload words, and word MAXW closes it even without `in_last`.
- R3: `in_ready` is low whenever NSLOT packets are held and not yet released.
- R4: An acknowledge (`ak_nak`=0) with number N releases N and every older held packet in one step, which frees room for new packets.
- R5: A negative acknowledge (`ak_nak`=1) with number N resends, starting at the next frame boundary, every held packet from N to the newest, in order, with unchanged sequence numbers, payload and CRC.
- R6: While sent packets remain unreleased, `replay_limit` cycles without a releasing acknowledge start a resend from the oldest held packet. No resend happens before that.
- R7: A number N is inside the window when (N minus the oldest held number) mod 4096 is less than the count of held packets already sent at least once. An acknowledge or negative acknowledge outside the window changes nothing and sets `seq_err`, which stays set until reset.
- R8: From a resend request until the last resent frame has left, `in_ready` is low.
- R9: Once `out_valid` is high, it stays high and `out_data`, `out_seq` and `out_last` do not change until `out_ready` accepts the word.
- R10: During and right after reset, `out_valid` is 0, `in_ready` is 1 and `seq_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Upstream word accepted when high together with valid |
| in_data | input | 32 | Upstream payload word |
| in_last | input | 1 | Marks the final payload word of a packet |
| out_valid | output | 1 | Downstream word valid |
| out_ready | input | 1 | Downstream can take a word |
| out_data | output | 32 | Payload or CRC word |
| out_last | output | 1 | High on the CRC word that closes a frame |
| out_seq | output | 12 | Sequence number of the frame in progress |
| ak_valid | input | 1 | Acknowledge strobe, one cycle |
| ak_nak | input | 1 | 0 = positive acknowledge, 1 = negative acknowledge |
| ak_seq | input | 12 | Sequence number carried by the acknowledge |
| replay_limit | input | TMR_W | Replay timer limit in cycles |
| seq_err | output | 1 | Sticky flag for an out-of-window acknowledge |

## Verification
Two events can collide on the same edge: a negative acknowledge arrives in the very cycle in which a new one-word packet is accepted and committed. The bench drives both strobes together. It then expects the resend to carry the two named older frames and, right after them, the new packet as its first transmission, all three with correct numbers and CRCs. It also expects `in_ready` to stay low until that third frame has gone.

// File: rtl/rtx_pkg.sv
package rtx_pkg;

    localparam int SEQ_W  = 12;
    localparam int WORD_W = 32;

    localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [WORD_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam seq_t SEQ_ONE = seq_t'(1);

    typedef enum logic {
        AK_POS = 1'b0,
        AK_NEG = 1'b1
    } ak_kind_e;

    // Fold one 32-bit word into the running CRC, most significant bit first.
    function automatic word_t crc_fold(word_t acc, word_t w);
        word_t c;
        logic  fb;
        c = acc;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            fb = c[WORD_W-1] ^ w[b];
            c  = {c[WORD_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    function automatic word_t seq_word(seq_t s);
        return {{(WORD_W-SEQ_W){1'b0}}, s};
    endfunction

endpackage

// File: rtl/rtx_framer.sv
module rtx_framer
    import rtx_pkg::*;
#(
    parameter int MAXW   = 4,
    parameter int SLOT_W = 2,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_ready,
    input  word_t             in_data,
    input  logic              in_last,
    output seq_t              next_seq,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [IDX_W-1:0]  wr_idx,
    output word_t             wr_data,
    output logic              fin,
    output logic [IDX_W-1:0]  fin_idx,
    output word_t             fin_crc
);

    logic [IDX_W-1:0] fill_q;
    seq_t             seq_q;
    word_t            crc_q, crc_base, crc_next;
    logic             take, at_end;

    assign take   = in_valid && in_ready;
    assign at_end = in_last || (fill_q == IDX_W'(MAXW - 1));

    always_comb begin
        crc_base = (fill_q == '0) ? crc_fold(CRC_SEED, seq_word(seq_q)) : crc_q;
        crc_next = crc_fold(crc_base, in_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
            seq_q  <= '0;
            crc_q  <= CRC_SEED;
        end else if (take) begin
            if (at_end) begin
                fill_q <= '0;
                seq_q  <= seq_q + SEQ_ONE;
            end else begin
                fill_q <= fill_q + IDX_W'(1);
                crc_q  <= crc_next;
            end
        end
    end

    assign next_seq = seq_q;
    assign wr_en    = take;
    assign wr_slot  = seq_q[SLOT_W-1:0];
    assign wr_idx   = fill_q;
    assign wr_data  = in_data;
    assign fin      = take && at_end;
    assign fin_idx  = fill_q + IDX_W'(1);
    assign fin_crc  = ~crc_next;

endmodule

// File: rtl/rtx_replay_mem.sv
module rtx_replay_mem
    import rtx_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int MAXW   = 4,
    parameter int SLOT_W = 2,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [IDX_W-1:0]  wr_idx,
    input  word_t             wr_data,
    input  logic              fin,
    input  logic [IDX_W-1:0]  fin_idx,
    input  word_t             fin_crc,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [IDX_W-1:0]  rd_idx,
    output word_t             rd_data,
    output logic [IDX_W-1:0]  rd_len
);

    localparam int ROWS = MAXW + 1;

    word_t            store [NSLOT][ROWS];
    logic [IDX_W-1:0] plen  [NSLOT];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_slot][wr_idx] <= wr_data;
        if (fin) begin
            store[wr_slot][fin_idx] <= fin_crc;
            plen[wr_slot]           <= fin_idx;
        end
    end

    assign rd_data = store[rd_slot][rd_idx];
    assign rd_len  = plen[rd_slot];

endmodule

// File: rtl/rtx_sender.sv
module rtx_sender
    import rtx_pkg::*;
#(
    parameter int SLOT_W = 2,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_t              base_seq,
    input  seq_t              next_seq,
    input  logic              rp_pend,
    input  seq_t              rp_seq,
    output logic              rp_take,
    output seq_t              sent_end,
    output logic              replaying,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [IDX_W-1:0]  rd_idx,
    input  word_t             rd_data,
    input  logic [IDX_W-1:0]  rd_len,
    output logic              out_valid,
    input  logic              out_ready,
    output word_t             out_data,
    output logic              out_last,
    output seq_t              out_seq
);

    seq_t             tx_q, sent_q;
    logic [IDX_W-1:0] word_q;
    logic             mid_q, replay_q;

    seq_t held, off, eff, cur, rp_off, rp_start;
    logic behind, avail, rp_ok, boundary, fire;

    always_comb begin
        held     = next_seq - base_seq;
        off      = tx_q - base_seq;
        behind   = off[SEQ_W-1];
        eff      = behind ? base_seq : tx_q;
        avail    = (eff - base_seq) < held;
        cur      = mid_q ? tx_q : eff;
        rp_off   = rp_seq - base_seq;
        rp_start = rp_off[SEQ_W-1] ? base_seq : rp_seq;
        rp_ok    = (rp_start - base_seq) < held;
        boundary = !mid_q;
    end

    assign rp_take   = boundary && rp_pend;
    assign out_valid = mid_q || (boundary && !rp_pend && avail);
    assign rd_slot   = cur[SLOT_W-1:0];
    assign rd_idx    = word_q;
    assign out_data  = rd_data;
    assign out_last  = (word_q == rd_len);
    assign out_seq   = cur;
    assign fire      = out_valid && out_ready;
    assign sent_end  = sent_q;
    assign replaying = replay_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q     <= '0;
            sent_q   <= '0;
            word_q   <= '0;
            mid_q    <= 1'b0;
            replay_q <= 1'b0;
        end else if (rp_take) begin
            if (rp_ok) begin
                tx_q     <= rp_start;
                replay_q <= 1'b1;
            end
        end else if (fire) begin
            if (out_last) begin
                word_q <= '0;
                mid_q  <= 1'b0;
                tx_q   <= cur + SEQ_ONE;
                if (cur == sent_q) sent_q <= cur + SEQ_ONE;
            end else begin
                word_q <= word_q + IDX_W'(1);
                mid_q  <= 1'b1;
                tx_q   <= cur;
            end
        end else if (out_valid) begin
            // Word presented but not taken: lock onto this frame.
            mid_q <= 1'b1;
            tx_q  <= cur;
        end else if (boundary) begin
            tx_q <= eff;
            if (!avail) replay_q <= 1'b0;
        end
    end

    // R9: a presented word is held until taken
    a_r9_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_seq) && $stable(out_last)));

    // R1: outside a resend, the frame on the wire is a held, unreleased packet
    a_r1_seq_in_window: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !replay_q) |-> ((out_seq - base_seq) < held));

endmodule

// File: rtl/rtx_retry_tx.sv
module rtx_retry_tx
    import rtx_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int MAXW  = 4,
    parameter int TMR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic              out_last,
    output logic [11:0]       out_seq,
    input  logic              ak_valid,
    input  logic              ak_nak,
    input  logic [11:0]       ak_seq,
    input  logic [TMR_W-1:0]  replay_limit,
    output logic              seq_err
);

    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int IDX_W  = $clog2(MAXW + 1);

    seq_t             base_q, rp_seq_q, next_seq, sent_end, held, win, ak_off;
    logic             rp_pend_q, err_q, rp_take, replaying;
    logic [TMR_W-1:0] tmr_q;
    logic             ak_in, ack_ok, nak_ok, ak_bad, outstanding, expire;
    ak_kind_e         kind;

    logic              wr_en, fin;
    logic [SLOT_W-1:0] wr_slot, rd_slot;
    logic [IDX_W-1:0]  wr_idx, fin_idx, rd_idx, rd_len;
    word_t             wr_data, fin_crc, rd_data;

    always_comb begin
        held        = next_seq - base_q;
        win         = sent_end - base_q;
        ak_off      = ak_seq - base_q;
        ak_in       = ak_off < win;
        kind        = ak_kind_e'(ak_nak);
        ack_ok      = ak_valid && ak_in && (kind == AK_POS);
        nak_ok      = ak_valid && ak_in && (kind == AK_NEG);
        ak_bad      = ak_valid && !ak_in;
        outstanding = (win != '0);
        expire      = outstanding && !rp_pend_q && !replaying && !ack_ok &&
                      ((tmr_q + TMR_W'(1)) >= replay_limit);
        in_ready    = (held < seq_t'(NSLOT)) && !replaying && !rp_pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            rp_pend_q <= 1'b0;
            rp_seq_q  <= '0;
            err_q     <= 1'b0;
            tmr_q     <= '0;
        end else begin
            if (ack_ok) base_q <= ak_seq + SEQ_ONE;
            if (ak_bad) err_q <= 1'b1;
            if (rp_take) rp_pend_q <= 1'b0;
            if (nak_ok) begin
                rp_pend_q <= 1'b1;
                rp_seq_q  <= ak_seq;
            end else if (expire) begin
                rp_pend_q <= 1'b1;
                rp_seq_q  <= base_q;
            end
            if (ack_ok || !outstanding || expire || rp_pend_q || replaying)
                tmr_q <= '0;
            else
                tmr_q <= tmr_q + TMR_W'(1);
        end
    end

    assign seq_err = err_q;

    rtx_framer #(.MAXW(MAXW), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_framer (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .next_seq(next_seq),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx), .wr_data(wr_data),
        .fin(fin), .fin_idx(fin_idx), .fin_crc(fin_crc)
    );

    rtx_replay_mem #(.NSLOT(NSLOT), .MAXW(MAXW), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_mem (
        .clk(clk),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx), .wr_data(wr_data),
        .fin(fin), .fin_idx(fin_idx), .fin_crc(fin_crc),
        .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_data(rd_data), .rd_len(rd_len)
    );

    rtx_sender #(.SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_sender (
        .clk(clk), .rst(rst),
        .base_seq(base_q), .next_seq(next_seq),
        .rp_pend(rp_pend_q), .rp_seq(rp_seq_q), .rp_take(rp_take),
        .sent_end(sent_end), .replaying(replaying),
        .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_data(rd_data), .rd_len(rd_len),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_seq(out_seq)
    );

    // R3: never more packets held than slots
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        held <= seq_t'(NSLOT));

    // R4: released point never passes the sent point, which never passes the commit point
    a_r4_window_order: assert property (@(posedge clk) disable iff (rst)
        win <= held);

    // R7: error flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R8: no new packet is committed while a resend runs
    a_r8_no_commit_in_replay: assert property (@(posedge clk) disable iff (rst)
        replaying |=> (next_seq == $past(next_seq)));

endmodule

// File: tb/tb_rtx_retry_tx.sv
module tb_rtx_retry_tx;

    localparam int CLK_PERIOD = 10;
    localparam int NPKT = 6;
    localparam int CAPN = 1024;
    localparam int TBL_LEN [NPKT] = '{1, 4, 2, 3, 1, 2};
    localparam logic [31:0] TBL_SEED [NPKT] = '{32'h1111_0000, 32'h2345_6789, 32'hDEAD_BEEF,
                                                32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000};

    logic        clk, rst;
    logic        in_valid, in_ready, in_last;
    logic [31:0] in_data;
    logic        out_valid, out_ready, out_last;
    logic [31:0] out_data;
    logic [11:0] out_seq;
    logic        ak_valid, ak_nak;
    logic [11:0] ak_seq;
    logic [15:0] replay_limit;
    logic        seq_err;

    rtx_retry_tx dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_seq(out_seq),
        .ak_valid(ak_valid), .ak_nak(ak_nak), .ak_seq(ak_seq),
        .replay_limit(replay_limit), .seq_err(seq_err)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    logic [11:0] nseq;

    logic [31:0] cap_data [CAPN];
    logic [11:0] cap_seq  [CAPN];
    logic        cap_last [CAPN];
    int          cap_n = 0;

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            cap_data[cap_n % CAPN] = out_data;
            cap_seq[cap_n % CAPN]  = out_seq;
            cap_last[cap_n % CAPN] = out_last;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(logic [31:0] c, logic [31:0] w);
        logic [31:0] r;
        r = c;
        for (int b = 31; b >= 0; b--) begin
            if (r[31] != w[b]) r = (r << 1) ^ 32'h04C1_1DB7;
            else               r = r << 1;
        end
        return r;
    endfunction

    function automatic logic [31:0] pkt_word(logic [31:0] seed, int k);
        return seed + 32'(k) * 32'h0101_0101;
    endfunction

    task automatic check_frame(int start, logic [11:0] seq, int len, logic [31:0] seed, string req);
        bit          ok;
        logic [31:0] act, exp, crc, e;
        int          ix;
        ok  = 1'b1;
        act = '0;
        exp = '0;
        crc = ref_crc(32'hFFFF_FFFF, {20'd0, seq});
        for (int k = 0; k <= len; k++) begin
            ix = (start + k) % CAPN;
            if (k < len) begin
                e   = pkt_word(seed, k);
                crc = ref_crc(crc, e);
            end else begin
                e = ~crc;
            end
            if (ok && (cap_data[ix] !== e || cap_seq[ix] !== seq || cap_last[ix] !== (k == len))) begin
                ok  = 1'b0;
                act = cap_data[ix];
                exp = e;
            end
        end
        chk(ok, req, $sformatf("frame seq %0d", seq), act, exp);
    endtask

    task automatic wait_cap(int target);
        while (cap_n < target) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic send_pkt(int len, logic [31:0] seed);
        for (int k = 0; k < len; k++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_data  = pkt_word(seed, k);
            in_last  = (k == len - 1);
            @(negedge clk);
            while (!in_ready) @(negedge clk);
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic send_ak(logic neg, logic [11:0] s);
        @(posedge clk); #1;
        ak_valid = 1'b1;
        ak_nak   = neg;
        ak_seq   = s;
        @(posedge clk); #1;
        ak_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cap_n);
        finish_run();
    end

    initial begin
        int          start, n0, mism;
        bit          saw_wrap;
        logic [31:0] d0;
        logic [11:0] s0;
        bit          stable_ok;

        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
        out_ready = 1'b1; ak_valid = 1'b0; ak_nak = 1'b0; ak_seq = '0;
        replay_limit = 16'd1000;
        nseq = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(out_valid == 1'b0, "R10", "out_valid", out_valid, 0);
        chk(in_ready == 1'b1,  "R10", "in_ready", in_ready, 1);
        chk(seq_err == 1'b0,   "R10", "seq_err", seq_err, 0);

        // Vector table: R1 numbering, R2 framing/CRC, R4 release
        for (int i = 0; i < NPKT; i++) begin
            start = cap_n;
            send_pkt(TBL_LEN[i], TBL_SEED[i]);
            wait_cap(start + TBL_LEN[i] + 1);
            chk(cap_seq[start % CAPN] == nseq, "R1", "sequence", cap_seq[start % CAPN], nseq);
            check_frame(start, nseq, TBL_LEN[i], TBL_SEED[i], "R2");
            send_ak(1'b0, nseq);
            nseq = nseq + 12'd1;
        end

        // R3: fill all slots without acknowledging
        n0 = int'(nseq);
        start = cap_n;
        for (int j = 0; j < 4; j++) send_pkt(1, 32'h0000_00A0 + 32'(j));
        nseq = nseq + 12'd4;
        wait_cap(start + 8);
        @(negedge clk);
        chk(in_ready == 1'b0, "R3", "in_ready at capacity", in_ready, 0);

        // R7: acknowledge far outside the window
        send_ak(1'b0, 12'(n0 + 100));
        @(negedge clk);
        chk(seq_err == 1'b1, "R7", "seq_err set", seq_err, 1);
        chk(in_ready == 1'b0, "R7", "ignored ack freed nothing", in_ready, 0);
        repeat (3) @(negedge clk);
        chk(seq_err == 1'b1, "R7", "seq_err sticky", seq_err, 1);

        // R4: cumulative release of two packets
        send_ak(1'b0, 12'(n0 + 1));
        @(negedge clk);
        chk(in_ready == 1'b1, "R4", "in_ready after release", in_ready, 1);
        chk(cap_n == start + 8, "R4", "no resend on ack", cap_n, start + 8);

        // R5/R8: negative acknowledge on the edge a new packet commits
        start = cap_n;
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = 32'hC0DE_0001; in_last = 1'b1;
        ak_valid = 1'b1; ak_nak = 1'b1; ak_seq = 12'(n0 + 2);
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0; ak_valid = 1'b0;
        nseq = nseq + 12'd1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R8", "ingress held during resend", in_ready, 0);
        wait_cap(start + 6);
        check_frame(start,     12'(n0 + 2), 1, 32'h0000_00A2, "R5");
        check_frame(start + 2, 12'(n0 + 3), 1, 32'h0000_00A3, "R5");
        check_frame(start + 4, 12'(n0 + 4), 1, 32'hC0DE_0001, "R5");
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R8", "ingress resumes after resend", in_ready, 1);
        send_ak(1'b0, 12'(n0 + 4));

        // R6: replay timer
        @(posedge clk); #1 replay_limit = 16'd40;
        start = cap_n;
        send_pkt(2, 32'h5555_AAAA);
        wait_cap(start + 3);
        check_frame(start, nseq, 2, 32'h5555_AAAA, "R6");
        repeat (20) @(negedge clk);
        chk(cap_n == start + 3, "R6", "no early resend", cap_n, start + 3);
        wait_cap(start + 6);
        check_frame(start + 3, nseq, 2, 32'h5555_AAAA, "R6");
        send_ak(1'b0, nseq);
        nseq = nseq + 12'd1;
        @(posedge clk); #1 replay_limit = 16'd1000;

        // R9: downstream stall
        @(posedge clk); #1 out_ready = 1'b0;
        send_pkt(3, 32'h0BAD_F00D);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b1, "R9", "out_valid while stalled", out_valid, 1);
        d0 = out_data;
        s0 = out_seq;
        stable_ok = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (!out_valid || out_data !== d0 || out_seq !== s0) stable_ok = 1'b0;
        end
        chk(stable_ok, "R9", "word stable while stalled", out_data, d0);
        start = cap_n;
        @(posedge clk); #1 out_ready = 1'b1;
        wait_cap(start + 4);
        check_frame(start, nseq, 3, 32'h0BAD_F00D, "R2");
        send_ak(1'b0, nseq);
        nseq = nseq + 12'd1;

        // R1: sequence wrap past 4095
        mism = 0;
        saw_wrap = 1'b0;
        n0 = 4096 - int'(nseq) + 3;
        for (int i = 0; i < n0; i++) begin
            start = cap_n;
            send_pkt(1, 32'(i));
            wait_cap(start + 2);
            if (cap_seq[start % CAPN] !== nseq) mism++;
            if (nseq == 12'd0 && cap_seq[start % CAPN] == 12'd0) saw_wrap = 1'b1;
            send_ak(1'b0, nseq);
            nseq = nseq + 12'd1;
        end
        chk(mism == 0, "R1", "numbering across wrap", mism, 0);
        chk(saw_wrap, "R1", "number 0 follows 4095", saw_wrap, 1);

        finish_run();
    end

endmodule